// File: doc/BRIEF.md
# Prescaled Timer Counter Core

This block is the counting heart of a general-purpose timer. It has an up-counter of configurable width, 32 bits by default. The counter advances on qualified ticks rather than on every clock. A three-bit source code picks one of five tick inputs; each tick input is a one-cycle enable in the block's own clock domain. The chosen tick then passes through a programmable divider before it reaches the counter. The crystal-reference input has its own small divider and a separate enable bit, ahead of the source selector.

Several controls decide what the counter does. It can keep its value while stopped, or it can clear to zero while stopped. It can wrap freely from all-ones to zero, or it can run in restart mode, where a match strobe from compare channel 1 reloads it to zero on the next divided tick. Each of four low-power mode inputs has its own run permission bit, so counting can freeze during debug, wait, doze or stop. A rollover flag, cleared by writing 1, drives an interrupt request through an enable. A software-reset request clears all internal state and holds it cleared for a fixed number of cycles, and a busy output shows this.

Top module: `prescaled_timer_core`

## Requirements
- R1: The main divider passes one counter tick for every (cfg_div+1) selected source ticks, with cfg_div from 0 (divide by 1) to all-ones (divide by 2^DIV_W). After a clear, the (cfg_div+1)-th source tick is the first one that advances the counter.
- R2: The crystal path passes one tick for every (cfg_xdiv+1) tick_xtal pulses while cfg_xtal_en is 1. While cfg_xtal_en is 0, the crystal path produces no ticks.
- R3: cfg_src selects the tick source: 0 none, 1 tick_periph, 2 tick_hf, 3 tick_ext, 4 tick_lf, 5 divided crystal path, and 6 and 7 none. Tick inputs that are not selected have no effect on count.
- R4: While cfg_run is 0, count holds its value if cfg_clr_off is 0, and count becomes 0 one clock later if cfg_clr_off is 1.
- R5: With cfg_freerun at 1, a counter tick at the all-ones value wraps count to 0.
- R6: rov_flag becomes 1 in the same clock edge at which count wraps from all-ones to zero. If a wrap and a clearing write happen in the same cycle, the set wins.
- R7: rov_irq is 1 exactly when rov_flag and cfg_rov_ie are both 1.
- R8: While one of the inputs lp_dbg, lp_wait, lp_doze or lp_stop is 1 and the matching run permission (cfg_run_dbg, cfg_run_wait, cfg_run_doze, cfg_run_stop) is 0, the counter and the main divider do not advance. When the permission is 1, counting continues.
- R9: With cfg_freerun at 0, a cmp1_hit pulse causes the next counter tick (the same cycle or a later one) to load 0 instead of incrementing. With cfg_freerun at 1, cmp1_hit has no effect.
- R10: A swr_req pulse clears count, rov_flag and both divider states at the next edge. swr_busy is then 1 for SRST_CYC cycles, ticks are ignored during that time, and swr_busy then returns to 0 by itself. The cfg inputs are not affected.
- R11: A cycle with st_wr at 1 and st_wdata at 1 clears rov_flag. With st_wdata at 0 the write leaves rov_flag unchanged.
- R12: After reset, count is 0, rov_flag is 0, rov_irq is 0 and swr_busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_run | input | 1 | Counter enable |
| cfg_clr_off | input | 1 | 1: clear count while disabled; 0: retain |
| cfg_freerun | input | 1 | 1: free-run wrap; 0: restart on compare 1 |
| cfg_src | input | 3 | Tick source code |
| cfg_div | input | DIV_W | Main divider value minus one |
| cfg_xtal_en | input | 1 | Crystal path enable |
| cfg_xdiv | input | XDIV_W | Crystal divider value minus one |
| cfg_run_dbg | input | 1 | Keep counting in debug mode |
| cfg_run_wait | input | 1 | Keep counting in wait mode |
| cfg_run_doze | input | 1 | Keep counting in doze mode |
| cfg_run_stop | input | 1 | Keep counting in stop mode |
| cfg_rov_ie | input | 1 | Rollover interrupt enable |
| lp_dbg | input | 1 | Debug mode active |
| lp_wait | input | 1 | Wait mode active |
| lp_doze | input | 1 | Doze mode active |
| lp_stop | input | 1 | Stop mode active |
| tick_periph | input | 1 | Peripheral clock tick |
| tick_hf | input | 1 | High-frequency reference tick |
| tick_ext | input | 1 | External clock tick |
| tick_lf | input | 1 | Low-frequency reference tick |
| tick_xtal | input | 1 | Crystal reference tick |
| cmp1_hit | input | 1 | Compare channel 1 match strobe |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 1 | Status write data for the rollover flag (1 clears) |
| swr_req | input | 1 | Software reset request pulse |
| count | output | CNT_W | Live counter value |
| rov_flag | output | 1 | Rollover status flag |
| rov_irq | output | 1 | Rollover interrupt request |
| swr_busy | output | 1 | Software reset in progress |

## Verification
A tick, disable, compare strobe, clearing write or reset request that is driven in one cycle shows up on count, rov_flag and swr_busy after the very next clock edge. There is no pipeline between the tick inputs and the counter, because both dividers emit their output in the same cycle as the tick that completes them. rov_irq follows rov_flag and cfg_rov_ie with no register in between. The bench changes inputs on the falling edge and reads outputs on the following falling edge, so every check samples exactly one rising edge after its stimulus. It uses an 8-bit counter so that a full wrap takes 256 ticks.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [2:0] {
        SRC_NONE   = 3'd0,
        SRC_PERIPH = 3'd1,
        SRC_HF     = 3'd2,
        SRC_EXT    = 3'd3,
        SRC_LF     = 3'd4,
        SRC_XTAL   = 3'd5
    } src_e;

    // Index of each tick line inside the packed tick vector
    localparam int TK_PERIPH = 0;
    localparam int TK_HF     = 1;
    localparam int TK_EXT    = 2;
    localparam int TK_LF     = 3;
    localparam int TK_XTAL   = 4;
    localparam int TK_N      = 5;

    typedef struct packed {
        logic dbg;
        logic lpwait;
        logic doze;
        logic stop;
    } lp_vec_t;

    function automatic logic pick_tick(input src_e sel, input logic [TK_N-1:0] tk);
        case (sel)
            SRC_PERIPH: pick_tick = tk[TK_PERIPH];
            SRC_HF:     pick_tick = tk[TK_HF];
            SRC_EXT:    pick_tick = tk[TK_EXT];
            SRC_LF:     pick_tick = tk[TK_LF];
            SRC_XTAL:   pick_tick = tk[TK_XTAL];
            default:    pick_tick = 1'b0;
        endcase
    endfunction

    function automatic logic lp_allows(input lp_vec_t mode, input lp_vec_t allow);
        return ((mode & ~allow) == '0);
    endfunction

endpackage

// File: rtl/ptc_divider.sv
module ptc_divider #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         en_in,
    input  logic [W-1:0] limit,
    output logic         tick_out
);
    logic [W-1:0] phase;
    logic         at_end;

    assign at_end   = (phase >= limit);
    assign tick_out = en_in && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase <= '0;
        end else if (en_in) begin
            phase <= at_end ? '0 : phase + 1'b1;
        end
    end

    // R1
    phase_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(limit) && phase <= limit) |=> (phase <= limit));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_in && !clear) |=> $stable(phase));
endmodule

// File: rtl/ptc_swr_seq.sv
module ptc_swr_seq #(
    parameter int SRST_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic busy
);
    localparam int CW = $clog2(SRST_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(SRST_CYC);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (req) begin
            remain <= LOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

    // R10
    swr_starts_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> busy);

    // R10
    swr_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (!req && remain == 1) |=> !busy);

    always_comb begin
        // R10
        swr_bound_chk: assert (remain <= LOAD);
    end
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic             clr_off,
    input  logic             freerun,
    input  logic             tick,
    input  logic             cmp_hit,
    input  logic             st_wr,
    input  logic             st_wdata,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic pend;
    logic reload;
    logic wrap;

    assign reload = !freerun && (pend || cmp_hit);
    assign wrap   = run && tick && !reload && (count == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
            pend  <= 1'b0;
        end else if (!run) begin
            if (clr_off) count <= '0;
            pend <= 1'b0;
        end else if (tick) begin
            count <= reload ? '0 : count + 1'b1;
            pend  <= 1'b0;
        end else if (cmp_hit && !freerun) begin
            pend <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            flag <= 1'b0;
        end else if (wrap) begin
            flag <= 1'b1;
        end else if (st_wr && st_wdata) begin
            flag <= 1'b0;
        end
    end

    // R5
    freerun_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && run && tick && freerun && count == CNT_MAX) |=> (count == '0));

    // R6
    flag_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && run && tick && freerun && count == CNT_MAX) |=> flag);

    // R4
    retain_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && !run && !clr_off) |=> $stable(count));

    // R4
    clear_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && clr_off) |=> (count == '0));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && run && tick && !freerun && cmp_hit) |=> (count == '0));

    // R11
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && st_wr && st_wdata && !(run && tick)) |=> !flag);
endmodule

// File: rtl/prescaled_timer_core.sv
module prescaled_timer_core
    import ptc_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int DIV_W    = 12,
    parameter int XDIV_W   = 4,
    parameter int SRST_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_run,
    input  logic              cfg_clr_off,
    input  logic              cfg_freerun,
    input  logic [2:0]        cfg_src,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_xtal_en,
    input  logic [XDIV_W-1:0] cfg_xdiv,
    input  logic              cfg_run_dbg,
    input  logic              cfg_run_wait,
    input  logic              cfg_run_doze,
    input  logic              cfg_run_stop,
    input  logic              cfg_rov_ie,
    input  logic              lp_dbg,
    input  logic              lp_wait,
    input  logic              lp_doze,
    input  logic              lp_stop,
    input  logic              tick_periph,
    input  logic              tick_hf,
    input  logic              tick_ext,
    input  logic              tick_lf,
    input  logic              tick_xtal,
    input  logic              cmp1_hit,
    input  logic              st_wr,
    input  logic              st_wdata,
    input  logic              swr_req,
    output logic [CNT_W-1:0]  count,
    output logic              rov_flag,
    output logic              rov_irq,
    output logic              swr_busy
);
    logic            swr_clear;
    logic            xtal_tick;
    logic [TK_N-1:0] tk_vec;
    logic            src_tick;
    logic            active;
    logic            cnt_tick;
    lp_vec_t         lp_mode;
    lp_vec_t         lp_allow;

    ptc_swr_seq #(.SRST_CYC(SRST_CYC)) swr_i (
        .clk  (clk),
        .rst  (rst),
        .req  (swr_req),
        .busy (swr_busy)
    );

    assign swr_clear = swr_req || swr_busy;

    ptc_divider #(.W(XDIV_W)) xdiv_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (swr_clear || !cfg_xtal_en),
        .en_in    (tick_xtal && cfg_xtal_en),
        .limit    (cfg_xdiv),
        .tick_out (xtal_tick)
    );

    assign tk_vec[TK_PERIPH] = tick_periph;
    assign tk_vec[TK_HF]     = tick_hf;
    assign tk_vec[TK_EXT]    = tick_ext;
    assign tk_vec[TK_LF]     = tick_lf;
    assign tk_vec[TK_XTAL]   = xtal_tick;

    assign src_tick = pick_tick(src_e'(cfg_src), tk_vec);

    assign lp_mode  = '{dbg: lp_dbg, lpwait: lp_wait, doze: lp_doze, stop: lp_stop};
    assign lp_allow = '{dbg: cfg_run_dbg, lpwait: cfg_run_wait,
                        doze: cfg_run_doze, stop: cfg_run_stop};
    assign active   = cfg_run && lp_allows(lp_mode, lp_allow);

    ptc_divider #(.W(DIV_W)) mdiv_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (swr_clear || !cfg_run),
        .en_in    (src_tick && active),
        .limit    (cfg_div),
        .tick_out (cnt_tick)
    );

    ptc_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (swr_clear),
        .run      (cfg_run),
        .clr_off  (cfg_clr_off),
        .freerun  (cfg_freerun),
        .tick     (cnt_tick),
        .cmp_hit  (cmp1_hit),
        .st_wr    (st_wr),
        .st_wdata (st_wdata),
        .count    (count),
        .flag     (rov_flag)
    );

    assign rov_irq = rov_flag && cfg_rov_ie;

    // R8
    lp_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!swr_clear && cfg_run && lp_stop && !cfg_run_stop) |=> $stable(count));

    // R10
    swr_holds_zero_chk: assert property (@(posedge clk) disable iff (rst)
        swr_busy |-> (count == '0 && !rov_flag));

    // R12
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (count == '0 && !rov_flag && !swr_busy));

    always_comb begin
        // R7
        irq_gate_chk: assert (!rov_irq || cfg_rov_ie);
    end
endmodule

// File: tb/prescaled_timer_core_tb_top.sv
module prescaled_timer_core_tb_top;
    localparam int CW = 8;
    localparam int DW = 12;
    localparam int XW = 4;
    localparam int SC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic cfg_run = 0, cfg_clr_off = 0, cfg_freerun = 1, cfg_xtal_en = 0, cfg_rov_ie = 0;
    logic [2:0] cfg_src = 3'd1;
    logic [DW-1:0] cfg_div = '0;
    logic [XW-1:0] cfg_xdiv = '0;
    logic [3:0] lp_allow = 4'b0000;  // dbg, wait, doze, stop
    logic [3:0] lp_mode = 4'b0000;
    logic [4:0] tk = '0;             // periph, hf, ext, lf, xtal
    logic cmp1_hit = 0, st_wr = 0, st_wdata = 0, swr_req = 0;
    logic [CW-1:0] count;
    logic rov_flag, rov_irq, swr_busy;

    int vectors = 0;
    int misses = 0;

    prescaled_timer_core #(.CNT_W(CW), .DIV_W(DW), .XDIV_W(XW), .SRST_CYC(SC)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_run(cfg_run), .cfg_clr_off(cfg_clr_off), .cfg_freerun(cfg_freerun),
        .cfg_src(cfg_src), .cfg_div(cfg_div), .cfg_xtal_en(cfg_xtal_en), .cfg_xdiv(cfg_xdiv),
        .cfg_run_dbg(lp_allow[3]), .cfg_run_wait(lp_allow[2]),
        .cfg_run_doze(lp_allow[1]), .cfg_run_stop(lp_allow[0]),
        .cfg_rov_ie(cfg_rov_ie),
        .lp_dbg(lp_mode[3]), .lp_wait(lp_mode[2]), .lp_doze(lp_mode[1]), .lp_stop(lp_mode[0]),
        .tick_periph(tk[0]), .tick_hf(tk[1]), .tick_ext(tk[2]), .tick_lf(tk[3]),
        .tick_xtal(tk[4]),
        .cmp1_hit(cmp1_hit), .st_wr(st_wr), .st_wdata(st_wdata), .swr_req(swr_req),
        .count(count), .rov_flag(rov_flag), .rov_irq(rov_irq), .swr_busy(swr_busy)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_ticks(input int line, input int n);
        for (int i = 0; i < n; i++) begin
            tk[line] = 1'b1;
            @(negedge clk);
        end
        tk = '0;
    endtask

    task automatic soft_reset();
        swr_req = 1'b1;
        @(negedge clk);
        swr_req = 1'b0;
        cyc(SC);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R12 reset state
        check("R12 count", count, 0);
        check("R12 flag", rov_flag, 0);
        check("R12 irq", rov_irq, 0);
        check("R12 busy", swr_busy, 0);

        cfg_run = 1'b1;
        cfg_src = 3'd1;

        // R1 main divider sweep
        for (int p = 0; p < 6; p++) begin
            cfg_div = DW'(p);
            soft_reset();
            pulse_ticks(0, 12);
            check("R1 divide", count, 12 / (p + 1));
        end
        cfg_div = '1;
        soft_reset();
        pulse_ticks(0, 4095);
        check("R1 max div below", count, 0);
        pulse_ticks(0, 1);
        check("R1 max div reach", count, 1);
        cfg_div = '0;

        // R3 source select: every code against every line
        cfg_xtal_en = 1'b1;
        cfg_xdiv = '0;
        for (int s = 0; s < 8; s++) begin
            for (int l = 0; l < 5; l++) begin
                cfg_src = 3'(s);
                soft_reset();
                pulse_ticks(l, 4);
                check("R3 select", count, (s == l + 1) ? 4 : 0);
            end
        end

        // R2 crystal divider and enable
        cfg_src = 3'd5;
        for (int x = 0; x < 4; x++) begin
            cfg_xdiv = XW'(x);
            soft_reset();
            pulse_ticks(4, 16);
            check("R2 xtal divide", count, 16 / (x + 1));
        end
        cfg_xtal_en = 1'b0;
        cfg_xdiv = '0;
        soft_reset();
        pulse_ticks(4, 5);
        check("R2 xtal off", count, 0);
        cfg_xtal_en = 1'b1;
        cfg_src = 3'd1;

        // R4 retain or clear on disable
        soft_reset();
        pulse_ticks(0, 5);
        cfg_clr_off = 1'b0;
        cfg_run = 1'b0;
        pulse_ticks(0, 3);
        check("R4 retain", count, 5);
        cfg_run = 1'b1;
        pulse_ticks(0, 2);
        check("R4 resume", count, 7);
        cfg_clr_off = 1'b1;
        cfg_run = 1'b0;
        cyc(1);
        check("R4 clear", count, 0);
        cfg_run = 1'b1;
        cfg_clr_off = 1'b0;

        // R5 R6 free-run wrap and flag
        cfg_freerun = 1'b1;
        soft_reset();
        pulse_ticks(0, 255);
        check("R5 at max", count, 255);
        check("R6 no flag yet", rov_flag, 0);
        pulse_ticks(0, 1);
        check("R5 wrap", count, 0);
        check("R6 flag set", rov_flag, 1);

        // R7 interrupt gate
        cfg_rov_ie = 1'b0;
        cyc(1);
        check("R7 irq masked", rov_irq, 0);
        cfg_rov_ie = 1'b1;
        cyc(1);
        check("R7 irq raised", rov_irq, 1);

        // R11 write-one-to-clear
        st_wr = 1'b1; st_wdata = 1'b0;
        cyc(1);
        st_wr = 1'b0;
        check("R11 write0 keeps", rov_flag, 1);
        st_wr = 1'b1; st_wdata = 1'b1;
        cyc(1);
        st_wr = 1'b0; st_wdata = 1'b0;
        check("R11 write1 clears", rov_flag, 0);
        check("R7 irq dropped", rov_irq, 0);

        // R6 set wins over a clearing write in the same cycle
        pulse_ticks(0, 255);
        tk[0] = 1'b1; st_wr = 1'b1; st_wdata = 1'b1;
        cyc(1);
        tk = '0; st_wr = 1'b0; st_wdata = 1'b0;
        check("R6 set wins", rov_flag, 1);
        cfg_rov_ie = 1'b0;

        // R9 restart on compare 1
        cfg_freerun = 1'b0;
        soft_reset();
        pulse_ticks(0, 10);
        cmp1_hit = 1'b1;
        cyc(1);
        cmp1_hit = 1'b0;
        cyc(2);
        check("R9 waits for tick", count, 10);
        pulse_ticks(0, 1);
        check("R9 reload", count, 0);
        pulse_ticks(0, 1);
        check("R9 counts on", count, 1);
        cfg_freerun = 1'b1;
        cmp1_hit = 1'b1;
        tk[0] = 1'b1;
        cyc(1);
        cmp1_hit = 1'b0;
        tk = '0;
        check("R9 ignored in free-run", count, 2);

        // R8 low-power gating, each mode with permission off then on
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 2; a++) begin
                soft_reset();
                lp_mode = 4'(1 << m);
                lp_allow = a ? 4'(1 << m) : 4'b0000;
                pulse_ticks(0, 3);
                check("R8 low-power", count, a ? 3 : 0);
                lp_mode = '0;
                lp_allow = '0;
            end
        end

        // R10 software reset sequence
        soft_reset();
        pulse_ticks(0, 255);
        pulse_ticks(0, 3);
        check("R10 pre state", count, 2);
        swr_req = 1'b1;
        cyc(1);
        swr_req = 1'b0;
        check("R10 count cleared", count, 0);
        check("R10 flag cleared", rov_flag, 0);
        check("R10 busy", swr_busy, 1);
        pulse_ticks(0, SC - 1);
        check("R10 busy held", swr_busy, 1);
        check("R10 ticks ignored", count, 0);
        cyc(1);
        check("R10 busy done", swr_busy, 0);
        pulse_ticks(0, 2);
        check("R10 config kept", count, 2);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule